// File: doc/BRIEF.md
# Ones-Complement Sequential Multiplier

This block multiplies two 12-bit signed words held in one's-complement form. One word is the accumulator value (multiplicand) and the other is a memory word (multiplier). A pulse on `start` while the unit is idle captures both words and a mode bit that selects an integer or a fractional reading of the operands. The unit strips the signs, forms the 11-bit magnitudes by complementing negative words, and builds the 22-bit magnitude product with one shift-and-add step per clock.

When the last step completes, the unit writes a signed 11-bit slice of the product into the accumulator output. Integer mode keeps the low slice and fractional mode keeps the high slice. The unsigned low 11 bits go left-justified into the MQ output, and the product sign goes to the link output. `done` pulses for one cycle when the new results appear. The results then stay unchanged until the next operation finishes. Operand fetch, address decoding and the overflow flag belong to the surrounding datapath. The caller forces integer mode when no effective address exists.

Top module: `oc_seq_mult`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `done` are 0 and `ac_out`, `mq_out` and `link_out` are all zero.
- R2: A `start` sampled high while `busy` is low sets `busy` from the next cycle. `busy` stays high for exactly 11 cycles. `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R3: A `start` sampled while `busy` is high is ignored. Changes on `mcand`, `mplier` and `frac_mode` after the accepted start have no effect on that operation's results.
- R4: Bit 11 of each operand is the sign, where 1 means negative. A negative operand's magnitude is the complement of its bits 10..0. The result sign is the XOR of the two operand signs, even when a magnitude is zero. This sign is driven on both `link_out` and `ac_out[11]`.
- R5: With `frac_mode` = 0, `ac_out[10:0]` holds the low 11 bits of the 22-bit magnitude product, complemented when the sign is negative. The upper product bits are dropped.
- R6: With `frac_mode` = 1, `ac_out[10:0]` holds the high 11 bits (21..11) of the magnitude product, complemented when the sign is negative.
- R7: In both modes, `mq_out[11:1]` holds the low 11 bits of the magnitude product, never complemented, and `mq_out[0]` is 0.
- R8: `ac_out`, `mq_out` and `link_out` change only in the cycle where `done` is high and hold their values otherwise. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | 12 | Multiplicand (accumulator), one's complement |
| mplier | input | 12 | Multiplier (memory word), one's complement |
| frac_mode | input | 1 | 1 selects fractional result, 0 integer |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: new results valid |
| ac_out | output | 12 | Signed product slice |
| mq_out | output | 12 | Unsigned low product bits, left-justified |
| link_out | output | 1 | Product sign |

## Verification
Two events can fall in the same cycle: the completion of one product (`done` with its result write) and the acceptance of the next request. The bench raises `start` in the very cycle it sees `done`. It then judges on every clock that the new operation runs its full 11 busy cycles, while the earlier results stay on the outputs until the second `done`. A request raised mid-run, together with operand and mode changes, is checked to leave both the timing and the result untouched.

// File: rtl/oc_mult_pkg.sv
`timescale 1ns/1ps
package oc_mult_pkg;
  parameter int unsigned OC_WORD_W = 12;
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } oc_mode_e;
endpackage

// File: rtl/oc_sign_mag.sv
`timescale 1ns/1ps
// Splits a one's-complement word into sign and magnitude.
module oc_sign_mag #(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned MAG_W = WORD_W - 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              neg,
  output logic [MAG_W-1:0]  mag
);
  always_comb begin
    neg = word[WORD_W-1];
    mag = neg ? ~word[MAG_W-1:0] : word[MAG_W-1:0];
  end
endmodule

// File: rtl/oc_mult_core.sv
`timescale 1ns/1ps
// Iterative shift-and-add magnitude multiplier, one step per clock.
module oc_mult_core #(
  parameter int unsigned MAG_W = 11,
  localparam int unsigned PROD_W = 2 * MAG_W,
  localparam int unsigned CNT_W  = $clog2(MAG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MAG_W-1:0]  mag_a,
  input  logic [MAG_W-1:0]  mag_b,
  output logic              busy,
  output logic              fin,
  output logic [PROD_W-1:0] prod_fin
);
  logic              busy_q, busy_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [MAG_W-1:0]  hi_q, hi_n, lo_q, lo_n, a_q, a_n;
  logic [MAG_W-1:0]  addend;
  logic [MAG_W:0]    sum;
  logic [PROD_W-1:0] stepped;
  logic              ce;

  always_comb begin
    addend   = lo_q[0] ? a_q : '0;
    sum      = {1'b0, hi_q} + {1'b0, addend};
    stepped  = {sum, lo_q[MAG_W-1:1]};
    fin      = busy_q && (cnt_q == CNT_W'(1));
    prod_fin = stepped;
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    hi_n   = hi_q;
    lo_n   = lo_q;
    a_n    = a_q;
    ce     = 1'b0;
    if (busy_q) begin
      ce     = 1'b1;
      hi_n   = stepped[PROD_W-1:MAG_W];
      lo_n   = stepped[MAG_W-1:0];
      cnt_n  = cnt_q - CNT_W'(1);
      busy_n = (cnt_q != CNT_W'(1));
    end else if (load) begin
      ce     = 1'b1;
      busy_n = 1'b1;
      cnt_n  = CNT_W'(MAG_W);
      hi_n   = '0;
      lo_n   = mag_b;
      a_n    = mag_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      a_q    <= '0;
    end else if (ce) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      a_q    <= a_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/oc_result_pack.sv
`timescale 1ns/1ps
// Formats the magnitude product into the signed AC, MQ and link values.
module oc_result_pack
  import oc_mult_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned MAG_W  = WORD_W - 1,
  localparam int unsigned PROD_W = 2 * MAG_W
) (
  input  logic [PROD_W-1:0] prod,
  input  logic              neg,
  input  oc_mode_e          mode,
  output logic [WORD_W-1:0] ac_val,
  output logic [WORD_W-1:0] mq_val,
  output logic              link_val
);
  logic [MAG_W-1:0] slice;
  always_comb begin
    slice    = (mode == MODE_FRAC) ? prod[PROD_W-1:MAG_W] : prod[MAG_W-1:0];
    ac_val   = {neg, (neg ? ~slice : slice)};
    mq_val   = {prod[MAG_W-1:0], 1'b0};
    link_val = neg;
  end
endmodule

// File: rtl/oc_seq_mult.sv
`timescale 1ns/1ps
module oc_seq_mult
  import oc_mult_pkg::*;
#(
  parameter int unsigned WORD_W = OC_WORD_W,
  localparam int unsigned MAG_W  = WORD_W - 1,
  localparam int unsigned PROD_W = 2 * MAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] mcand,
  input  logic [WORD_W-1:0] mplier,
  input  logic              frac_mode,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] ac_out,
  output logic [WORD_W-1:0] mq_out,
  output logic              link_out
);
  logic [1:0][WORD_W-1:0] opw;
  logic [1:0]             op_neg;
  logic [1:0][MAG_W-1:0]  op_mag;

  assign opw[0] = mcand;
  assign opw[1] = mplier;

  for (genvar g = 0; g < 2; g++) begin : g_op
    oc_sign_mag #(.WORD_W(WORD_W)) u_sm (
      .word (opw[g]),
      .neg  (op_neg[g]),
      .mag  (op_mag[g])
    );
  end

  logic              core_busy, core_fin, accept;
  logic [PROD_W-1:0] prod_fin;

  assign accept = start && !core_busy;

  oc_mult_core #(.MAG_W(MAG_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .mag_a    (op_mag[0]),
    .mag_b    (op_mag[1]),
    .busy     (core_busy),
    .fin      (core_fin),
    .prod_fin (prod_fin)
  );

  logic     sign_q, sign_n;
  oc_mode_e mode_q, mode_n;
  logic [WORD_W-1:0] ac_q, ac_n, mq_q, mq_n, ac_fmt, mq_fmt;
  logic link_q, link_n, link_fmt, done_q, done_n;

  oc_result_pack #(.WORD_W(WORD_W)) u_pack (
    .prod     (prod_fin),
    .neg      (sign_q),
    .mode     (mode_q),
    .ac_val   (ac_fmt),
    .mq_val   (mq_fmt),
    .link_val (link_fmt)
  );

  always_comb begin
    sign_n = sign_q;
    mode_n = mode_q;
    if (accept) begin
      sign_n = op_neg[0] ^ op_neg[1];
      mode_n = frac_mode ? MODE_FRAC : MODE_INT;
    end
    ac_n   = core_fin ? ac_fmt   : ac_q;
    mq_n   = core_fin ? mq_fmt   : mq_q;
    link_n = core_fin ? link_fmt : link_q;
    done_n = core_fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      mode_q <= MODE_INT;
    end else if (accept) begin
      sign_q <= sign_n;
      mode_q <= mode_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q   <= '0;
      mq_q   <= '0;
      link_q <= 1'b0;
    end else if (core_fin) begin
      ac_q   <= ac_n;
      mq_q   <= mq_n;
      link_q <= link_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign busy     = core_busy;
  assign done     = done_q;
  assign ac_out   = ac_q;
  assign mq_out   = mq_q;
  assign link_out = link_q;
endmodule

// File: rtl/oc_seq_mult_chk.sv
`timescale 1ns/1ps
module oc_seq_mult_chk #(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned MAG_W = WORD_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] ac_out,
  input logic [WORD_W-1:0] mq_out,
  input logic              link_out
);
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q == 16'(MAG_W)));
  assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_sign_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (link_out == ac_out[WORD_W-1]));
  assert_mq_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mq_out[0] == 1'b0);
  assert_ac_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac_out) |-> done);
  assert_mq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mq_out) |-> done);
endmodule

bind oc_seq_mult oc_seq_mult_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .ac_out   (ac_out),
  .mq_out   (mq_out),
  .link_out (link_out)
);

// File: tb/sim_oc_seq_mult.sv
`timescale 1ns/1ps
module sim_oc_seq_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] mcand = '0, mplier = '0;
  logic frac_mode = 1'b0;
  logic busy, done, link_out;
  logic [11:0] ac_out, mq_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  oc_seq_mult u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .frac_mode(frac_mode), .busy(busy), .done(done), .ac_out(ac_out),
    .mq_out(mq_out), .link_out(link_out)
  );

  // behavioural reference model
  logic m_busy, m_done, m_link;
  int   m_left;
  logic [11:0] m_a, m_b, m_ac, m_mq;
  logic m_frac;

  task automatic calc(input logic [11:0] a, input logic [11:0] b, input logic f,
                      output logic [11:0] ac, output logic [11:0] mq, output logic lk);
    int ma, mb, p, sel;
    logic s;
    ma = a[11] ? (~a & 12'h7FF) : (a & 12'h7FF);
    mb = b[11] ? (~b & 12'h7FF) : (b & 12'h7FF);
    p  = ma * mb;
    s  = a[11] ^ b[11];
    sel = f ? ((p >> 11) & 2047) : (p & 2047);
    ac = {s, (s ? ~11'(sel) : 11'(sel))};
    mq = {11'(p & 2047), 1'b0};
    lk = s;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_ac = 0; m_mq = 0; m_link = 0;
      m_a = 0; m_b = 0; m_frac = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          calc(m_a, m_b, m_frac, m_ac, m_mq, m_link);
        end
      end else if (start) begin
        m_busy = 1; m_left = 11; m_a = mcand; m_b = mplier; m_frac = frac_mode;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%o expected=%o at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == m_busy, "R2 R3 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R2 done", 32'(done), 32'(m_done));
      chk(ac_out == m_ac, "R4 R5 R6 R8 ac", 32'(ac_out), 32'(m_ac));
      chk(mq_out == m_mq, "R7 R8 mq", 32'(mq_out), 32'(m_mq));
      chk(link_out == m_link, "R4 link", 32'(link_out), 32'(m_link));
    end
  end

  task automatic issue(input logic [11:0] a, input logic [11:0] b, input logic f);
    @(negedge clk);
    mcand = a; mplier = b; frac_mode = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic op_expect(input logic [11:0] a, input logic [11:0] b, input logic f,
                           input logic [11:0] eac, input logic [11:0] emq, input string tag);
    issue(a, b, f);
    wait_done();
    chk(ac_out == eac, tag, 32'(ac_out), 32'(eac));
    chk(mq_out == emq, tag, 32'(mq_out), 32'(emq));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  logic [31:0] st = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
    chk(ac_out == 0 && mq_out == 0 && !link_out, "R1 results", {ac_out, mq_out}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ac_out == 0, "R1 after release", {busy, ac_out}, 0);

    op_expect(12'o2764, 12'o0153, 1'b0, 12'o2374, 12'o4770, "R5 R7 int positive");
    op_expect(12'o2764, 12'o7624, 1'b0, 12'o5403, 12'o4770, "R4 R5 int negative");
    op_expect(12'o2764, 12'o0153, 1'b1, 12'o0117, 12'o4770, "R6 frac positive");
    op_expect(12'o2764, 12'o7624, 1'b1, 12'o7660, 12'o4770, "R4 R6 frac negative");
    op_expect(12'o7777, 12'o0005, 1'b0, 12'o7777, 12'o0000, "R4 negative zero");
    chk(link_out == 1'b1, "R4 link on negative zero", 32'(link_out), 1);
    op_expect(12'o3777, 12'o3777, 1'b0, 12'o0001, 12'o0002, "R5 max magnitude");
    op_expect(12'o4000, 12'o4000, 1'b1, 12'o3776, 12'o0002, "R4 R6 both negative max");

    // R3: start and operand/mode changes mid-run are ignored
    issue(12'o0432, 12'o0006, 1'b0);
    repeat (3) @(negedge clk);
    mcand = 12'o7000; mplier = 12'o1234; frac_mode = 1'b1; start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done();
    chk(ac_out == 12'o3234 && mq_out == 12'o6470, "R3 ignored start", {ac_out, mq_out}, {12'o3234, 12'o6470});

    // R8: start in the done cycle, earlier results held through next run
    mcand = 12'o2764; mplier = 12'o0153; frac_mode = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R8 start on done accepted", 32'(busy), 1);
    repeat (5) @(negedge clk);
    chk(ac_out == 12'o3234, "R8 hold during run", 32'(ac_out), 32'(12'o3234));
    wait_done();
    chk(ac_out == 12'o2374, "R8 second result", 32'(ac_out), 32'(12'o2374));

    // varied operands, compared each cycle against the model
    for (int i = 0; i < 40; i++) begin
      st = st * 32'd1103515245 + 32'd12345;
      issue(st[27:16], st[11:0], st[31]);
      wait_done();
      if (st[30]) repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule